// File: doc/BRIEF.md
# Double-Buffered Serial Master

This block is a serial-peripheral master that a processor drives through a small register window. A byte written to the data register waits in a holding register. It moves into the shift register as soon as that register is idle or has just finished a byte. Software can therefore queue the next byte while the current one is still on the wire, and queued bytes leave with no idle gap between them.

Each finished byte is copied into a receive register and raises a ready flag. Software clears that flag with a fixed handshake: it reads the status register while the flag is set, then reads the data register. A byte that finishes while the previous one is still unread is discarded and raises an overrun flag. Three per-flag enables gate the flags onto a single interrupt line. That line also serves as the wake-up request, because the block keeps shifting while the processor sleeps. A debug-halt input can freeze the transmit path so that stray data writes are ignored.

The serial clock is derived from the system clock by a fixed divide-by-2N counter. Polarity and phase are chosen by two control bits.

Top module: `spi_dbuf_master`

## Requirements
- R1: After reset, the status register (address 0) reads 0x01, the control register (address 1) reads 0x00, ss_n_o and sclk_o are high and low respectively, and irq_o is low.
- R2: A write to the data register (address 2) loads the holding register and clears status bit 0 (transmit empty). The bit returns to 1 when the shift register takes the byte.
- R3: A queued byte enters the shift register on the same clock edge on which the previous byte ends. Two bytes queued back to back keep ss_n_o low for exactly 2*2*DATA_W*HALF_DIV clock cycles.
- R4: Each byte is DATA_W bits, most significant bit first, on mosi_o and miso_i, with ss_n_o low during transfers. sclk_o idles at control bit 0 (polarity). With control bit 1 (phase) at 0, miso_i is sampled on the leading edge and mosi_o changes on the trailing edge. With phase at 1, mosi_o changes on the leading edge and miso_i is sampled on the trailing edge.
- R5: At the end of each byte the received value enters the receive register, which reads at address 2, and status bit 1 (receive full) is set.
- R6: Status bits 1 and 2 are cleared only by a status read made while either of them is set, followed by a data read. A data read alone clears nothing.
- R7: A byte that completes while status bit 1 is still set sets status bit 2 (overrun). The new byte is discarded and the receive register keeps the earlier one.
- R8: irq_o is the OR of three terms: status bit 0 AND control bit 2, status bit 1 AND control bit 3, and status bit 2 AND control bit 4.
- R9: While brk_i is high and control bit 5 is 0, a data write is ignored: status bit 0 stays 1 and no transfer starts.
- R10: While brk_i is high and control bit 5 is 1, data writes load and transmit normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write qualifier |
| bus_rd | input | 1 | Read qualifier |
| bus_addr | input | 2 | Register select: 0 status, 1 control, 2 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| brk_i | input | 1 | Debug halt |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ss_n_o | output | 1 | Slave select, active low |
| irq_o | output | 1 | Interrupt and wake-up request |

## Verification
The hardest case to reach from the ports is the gapless hand-over. The second byte must already be waiting when the first ends, and the first received byte must be read out before the second overwrites or overruns it. The stimulus polls the transmit-empty bit, queues the second byte at once, then polls receive-full and drains the first byte while the second is still shifting. It repeats this in all four polarity and phase combinations. A bench slave answers on miso_i, samples on the edges that each mode defines, and feeds a scoreboard of the bytes it sees on mosi_o.

// File: rtl/spi_dbuf_pkg.sv
`timescale 1ns/1ps
package spi_dbuf_pkg;

    typedef enum logic [1:0] {
        REG_STAT = 2'd0,
        REG_CTRL = 2'd1,
        REG_DATA = 2'd2
    } reg_sel_e;

    localparam int STAT_TXE = 0;
    localparam int STAT_RXF = 1;
    localparam int STAT_OVR = 2;

    // packed MSB first: bit5 .. bit0
    typedef struct packed {
        logic brk_clr_en;
        logic err_ie;
        logic rx_ie;
        logic tx_ie;
        logic pha;
        logic pol;
    } spi_ctrl_t;

    localparam int CTRL_W = $bits(spi_ctrl_t);

endpackage

// File: rtl/spi_half_tick.sv
`timescale 1ns/1ps
module spi_half_tick #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] TOP = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign tick = run && (cnt_q == TOP);

    always_comb begin
        cnt_d = cnt_q + 1'b1;
        if (!run || tick) cnt_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/spi_shift_core.sv
`timescale 1ns/1ps
module spi_shift_core #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              pol,
    input  logic              pha,
    input  logic              hold_valid,
    input  logic [DATA_W-1:0] hold_data,
    input  logic              miso,
    output logic              take,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rx_byte,
    output logic              sclk,
    output logic              mosi
);
    localparam int HW = $clog2(2 * DATA_W);
    localparam logic [HW-1:0] LAST_H = HW'(2 * DATA_W - 1);

    typedef struct packed {
        logic              busy;
        logic [HW-1:0]     h;
        logic [DATA_W-1:0] tx;
        logic [DATA_W-1:0] rx;
    } core_t;

    core_t d, q;
    logic [HW-1:0] nxt_h;
    logic          lead;

    always_comb begin
        d     = q;
        done  = q.busy && tick && (q.h == LAST_H);
        take  = hold_valid && (!q.busy || done);
        nxt_h = (q.h == LAST_H) ? '0 : q.h + 1'b1;
        lead  = nxt_h[0];
        if (q.busy && tick) begin
            d.h = nxt_h;
            if (!pha) begin
                if (lead)       d.rx = {q.rx[DATA_W-2:0], miso};
                else if (!done) d.tx = {q.tx[DATA_W-2:0], 1'b0};
            end else begin
                if (lead && q.h != '0) d.tx = {q.tx[DATA_W-2:0], 1'b0};
                else if (!lead)        d.rx = {q.rx[DATA_W-2:0], miso};
            end
            if (done) d.busy = 1'b0;
        end
        if (take) begin
            d.busy = 1'b1;
            d.h    = '0;
            d.tx   = hold_data;
        end
    end

    assign rx_byte = pha ? {q.rx[DATA_W-2:0], miso} : q.rx;
    assign busy    = q.busy;
    assign sclk    = pol ^ (q.busy & q.h[0]);
    assign mosi    = q.tx[DATA_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/spi_dbuf_master.sv
`timescale 1ns/1ps
module spi_dbuf_master
    import spi_dbuf_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int HALF_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              brk_i,
    output logic              sclk_o,
    output logic              mosi_o,
    input  logic              miso_i,
    output logic              ss_n_o,
    output logic              irq_o
);
    typedef struct packed {
        logic              tx_full;
        logic [DATA_W-1:0] hold;
        logic              rx_full;
        logic              ovr;
        logic              armed;
        logic [DATA_W-1:0] rx_data;
        spi_ctrl_t         ctrl;
    } regs_t;

    regs_t st_d, st_q;

    logic tick, take, busy, done;
    logic [DATA_W-1:0] rx_byte;
    logic wr_data, wr_ctrl, rd_stat, rd_data, blocked, clr, rx_busy_eff;
    logic unused_hi;

    assign unused_hi = ^bus_wdata[DATA_W-1:CTRL_W];

    spi_half_tick #(.HALF_DIV(HALF_DIV)) i_tick (
        .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick)
    );

    spi_shift_core #(.DATA_W(DATA_W)) i_core (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .pol(st_q.ctrl.pol), .pha(st_q.ctrl.pha),
        .hold_valid(st_q.tx_full), .hold_data(st_q.hold), .miso(miso_i),
        .take(take), .busy(busy), .done(done), .rx_byte(rx_byte),
        .sclk(sclk_o), .mosi(mosi_o)
    );

    always_comb begin
        st_d    = st_q;
        wr_data = bus_sel && bus_wr && (bus_addr == REG_DATA);
        wr_ctrl = bus_sel && bus_wr && (bus_addr == REG_CTRL);
        rd_stat = bus_sel && bus_rd && (bus_addr == REG_STAT);
        rd_data = bus_sel && bus_rd && (bus_addr == REG_DATA);
        blocked = brk_i && !st_q.ctrl.brk_clr_en;
        clr     = rd_data && st_q.armed;

        if (take) st_d.tx_full = 1'b0;
        if (wr_data && !blocked) begin
            st_d.tx_full = 1'b1;
            st_d.hold    = bus_wdata;
        end
        if (wr_ctrl) st_d.ctrl = spi_ctrl_t'(bus_wdata[CTRL_W-1:0]);

        if (rd_stat && (st_q.rx_full || st_q.ovr)) st_d.armed = 1'b1;
        if (clr) begin
            st_d.rx_full = 1'b0;
            st_d.ovr     = 1'b0;
            st_d.armed   = 1'b0;
        end
        rx_busy_eff = st_q.rx_full && !clr;
        if (done) begin
            if (rx_busy_eff) st_d.ovr = 1'b1;
            else begin
                st_d.rx_full = 1'b1;
                st_d.rx_data = rx_byte;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            REG_STAT: begin
                bus_rdata[STAT_TXE] = !st_q.tx_full;
                bus_rdata[STAT_RXF] = st_q.rx_full;
                bus_rdata[STAT_OVR] = st_q.ovr;
            end
            REG_CTRL: bus_rdata[CTRL_W-1:0] = st_q.ctrl;
            REG_DATA: bus_rdata = st_q.rx_data;
            default:  bus_rdata = '0;
        endcase
    end

    assign ss_n_o = !busy;
    assign irq_o  = (!st_q.tx_full && st_q.ctrl.tx_ie)
                  | (st_q.rx_full && st_q.ctrl.rx_ie)
                  | (st_q.ovr && st_q.ctrl.err_ie);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/spi_dbuf_checks.sv
`timescale 1ns/1ps
module spi_dbuf_checks
    import spi_dbuf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [1:0]        bus_addr,
    input logic              brk_i,
    input logic              ss_n_o,
    input logic              irq_o,
    input logic              tx_full,
    input logic              rx_full,
    input logic              ovr,
    input logic [DATA_W-1:0] rx_data,
    input spi_ctrl_t         ctrl
);
    logic data_wr, data_rd;
    assign data_wr = bus_sel && bus_wr && (bus_addr == REG_DATA);
    assign data_rd = bus_sel && bus_rd && (bus_addr == REG_DATA);

    // R9
    brk_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && brk_i && !ctrl.brk_clr_en && !tx_full) |=> !tx_full);

    // R6
    rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_full) |-> $past(data_rd));

    // R7
    ovr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> $past(rx_full));

    // R7
    rx_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && $past(rx_full) && !$past(data_rd)) |-> $stable(rx_data));

    // R3
    start_from_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ss_n_o) |-> $past(tx_full));

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl.tx_ie || ctrl.rx_ie || ctrl.err_ie) |-> !irq_o);
endmodule

bind spi_dbuf_master spi_dbuf_checks #(.DATA_W(DATA_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .brk_i(brk_i),
    .ss_n_o(ss_n_o), .irq_o(irq_o),
    .tx_full(st_q.tx_full), .rx_full(st_q.rx_full), .ovr(st_q.ovr),
    .rx_data(st_q.rx_data), .ctrl(st_q.ctrl)
);

// File: tb/test_spi_dbuf_master.sv
`timescale 1ns/1ps
module test_spi_dbuf_master;
    localparam int DW = 8;
    localparam int HD = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_sel = 0, bus_wr = 0, bus_rd = 0, brk = 0;
    logic [1:0] bus_addr = 0;
    logic [DW-1:0] bus_wdata = 0, bus_rdata;
    logic sclk, mosi, ss_n, irq;
    logic miso_r = 1'b0;

    int checks = 0, errors = 0, cycles = 0;
    logic [DW-1:0] exp_mosi[$];
    logic [DW-1:0] slave_q[$];
    logic tb_pol = 0, tb_pha = 0;

    spi_dbuf_master #(.DATA_W(DW), .HALF_DIV(HD)) i_spi_dbuf_master (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .brk_i(brk), .sclk_o(sclk), .mosi_o(mosi),
        .miso_i(miso_r), .ss_n_o(ss_n), .irq_o(irq)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // ss_n low-run measurement and pre-edge copies of mosi and ss_n
    int run_len = 0, last_run = 0;
    bit low_seen = 0;
    logic mosi_prev = 0, ss_prev = 1;
    always @(negedge clk) begin
        mosi_prev <= mosi;
        ss_prev   <= ss_n;
        if (!ss_n) begin run_len++; low_seen = 1; end
        else if (run_len != 0) begin last_run = run_len; run_len = 0; end
    end

    // Slave model and monitor side of the scoreboard
    logic [DW-1:0] s_tx = 0, s_cap = 0;
    int s_cnt = 0;
    bit fresh = 1;

    task automatic slave_drive();
        if (fresh) begin
            s_tx  = (slave_q.size() != 0) ? slave_q.pop_front() : '0;
            fresh = 0;
        end else begin
            s_tx = {s_tx[DW-2:0], 1'b0};
        end
        miso_r = s_tx[DW-1];
    endtask

    always @(negedge ss_n) begin
        s_cnt = 0;
        fresh = 1;
        if (!tb_pha) slave_drive();
    end

    always @(sclk) begin
        if (ss_prev == 1'b0) begin
            if ((sclk != tb_pol) == !tb_pha) begin
                s_cap = {s_cap[DW-2:0], mosi_prev};
                s_cnt++;
                if (s_cnt == DW) begin
                    s_cnt = 0;
                    fresh = 1;
                    if (exp_mosi.size() == 0) chk(0, "R4 mosi unexpected", s_cap, 0);
                    else begin
                        logic [DW-1:0] e;
                        e = exp_mosi.pop_front();
                        chk(s_cap == e, "R4 mosi byte", s_cap, e);
                    end
                end
            end else begin
                #1;
                if (!ss_n) slave_drive();
            end
        end
    end

    task automatic bus_write(input logic [1:0] a, input logic [DW-1:0] v);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [DW-1:0] v);
        @(negedge clk);
        bus_sel = 1; bus_rd = 1; bus_addr = a;
        #2 v = bus_rdata;
        @(negedge clk);
        bus_sel = 0; bus_rd = 0;
    endtask

    // driver side: queue expected mosi byte and the slave's reply
    task automatic send(input logic [DW-1:0] tx, input logic [DW-1:0] rx);
        exp_mosi.push_back(tx);
        slave_q.push_back(rx);
        bus_write(2'd2, tx);
    endtask

    task automatic set_ctrl(input logic [DW-1:0] v);
        tb_pol = v[0];
        tb_pha = v[1];
        bus_write(2'd1, v);
    endtask

    task automatic wait_idle();
        wait (ss_n == 1'b0);
        wait (ss_n == 1'b1);
        repeat (2) @(negedge clk);
    endtask

    task automatic poll(input int bitn);
        logic [DW-1:0] s;
        for (int k = 0; k < 500; k++) begin
            bus_read(2'd0, s);
            if (s[bitn]) break;
        end
    endtask

    logic [DW-1:0] v;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        bus_read(2'd0, v); chk(v == 8'h01, "R1 status", v, 8'h01);
        bus_read(2'd1, v); chk(v == 8'h00, "R1 control", v, 8'h00);
        chk(ss_n == 1 && sclk == 0 && irq == 0, "R1 pins", {ss_n, sclk, irq}, 3'b100);

        // R3/R4/R5 back-to-back in every mode
        for (int m = 0; m < 4; m++) begin
            logic [DW-1:0] t1, t2, r1, r2;
            t1 = 8'hA5 ^ DW'(m * 17); t2 = 8'h3C + DW'(m);
            r1 = 8'h96 ^ DW'(m * 5);  r2 = 8'h81 - DW'(m);
            set_ctrl(DW'(m));
            @(negedge clk);
            chk(sclk == m[0], "R4 idle clock level", sclk, m[0]);
            send(t1, r1);
            poll(0);
            send(t2, r2);
            bus_read(2'd0, v); chk(v == 8'h00, "R2 holding full", v, 8'h00);
            poll(1);
            bus_read(2'd2, v); chk(v == r1, "R5 first byte", v, r1);
            wait (ss_n == 1'b1);
            repeat (2) @(negedge clk);
            chk(last_run == 2 * 2 * DW * HD, "R3 no gap", last_run, 2 * 2 * DW * HD);
            bus_read(2'd0, v); chk(v == 8'h03, "R5 status after second", v, 8'h03);
            bus_read(2'd2, v); chk(v == r2, "R5 second byte", v, r2);
            bus_read(2'd0, v); chk(v == 8'h01, "R6 cleared", v, 8'h01);
        end

        // R6 data read alone clears nothing
        set_ctrl(8'h00);
        send(8'h5E, 8'hC3);
        wait_idle();
        bus_read(2'd2, v); chk(v == 8'hC3, "R6 data", v, 8'hC3);
        bus_read(2'd0, v); chk(v == 8'h03, "R6 not cleared by lone read", v, 8'h03);
        bus_read(2'd2, v);
        bus_read(2'd0, v); chk(v == 8'h01, "R6 sequence clears", v, 8'h01);

        // R7 overflow with error interrupt enabled (phase 1, polarity 0)
        set_ctrl(8'h12);
        send(8'h11, 8'h4B);
        wait_idle();
        chk(irq == 0, "R8 no error yet", irq, 0);
        send(8'h22, 8'hE7);
        wait_idle();
        chk(irq == 1, "R8 overrun irq", irq, 1);
        bus_read(2'd0, v); chk(v == 8'h07, "R7 overrun status", v, 8'h07);
        bus_read(2'd2, v); chk(v == 8'h4B, "R7 earlier byte kept", v, 8'h4B);
        bus_read(2'd0, v); chk(v == 8'h01, "R7 flags cleared", v, 8'h01);
        chk(irq == 0, "R8 irq drops", irq, 0);

        // R8 transmit-empty and receive-full enables
        set_ctrl(8'h04);
        @(negedge clk);
        chk(irq == 1, "R8 tx empty irq", irq, 1);
        set_ctrl(8'h08);
        @(negedge clk);
        chk(irq == 0, "R8 rx enable only, empty", irq, 0);
        send(8'h69, 8'h2D);
        wait_idle();
        chk(irq == 1, "R8 rx full irq", irq, 1);
        bus_read(2'd0, v);
        bus_read(2'd2, v); chk(v == 8'h2D, "R5 data", v, 8'h2D);
        chk(irq == 0, "R8 rx irq cleared", irq, 0);

        // R9 break blocks data writes
        set_ctrl(8'h00);
        brk = 1;
        low_seen = 0;
        bus_write(2'd2, 8'hF0);
        bus_read(2'd0, v); chk(v == 8'h01, "R9 tx empty stays", v, 8'h01);
        repeat (40) @(negedge clk);
        chk(low_seen == 0, "R9 no transfer", low_seen, 0);

        // R10 break with clear-enable set
        set_ctrl(8'h20);
        send(8'h0F, 8'hB4);
        wait_idle();
        bus_read(2'd0, v); chk(v == 8'h03, "R10 transfer done", v, 8'h03);
        bus_read(2'd2, v); chk(v == 8'hB4, "R10 data", v, 8'hB4);
        brk = 0;

        repeat (4) @(negedge clk);
        chk(exp_mosi.size() == 0, "R4 scoreboard drained", exp_mosi.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule